// File: doc/BRIEF.md
# Serial Port Register Front-End with Single-Slot Receive Buffer

This block is the software-visible register file of a serial port controller. A simple word-indexed bus reads and writes it through single-cycle strobes, and it returns read data one cycle after each read strobe. The control, status, test, FIFO-control and baud-setting registers live here. The baud and FIFO-control words only hold whatever software stores in them. No bit timing or pin-level serialisation takes place inside the block.

On the character side, one receive slot takes a byte or a break marker through a valid/ready handshake. A read of the receive-data word hands that slot to software. The ready flag, the data-ready flag and the empty flag sit in three different registers, and they always change together. A write to the transmit-data word leaves the block as a one-cycle byte strobe, but only while transmission is enabled. One level interrupt combines the receive-ready and transmit-ready conditions with their enables. Writing the control-2 word with bit 0 low applies a soft reset to most of the registers.

Top module: `uart_regfront`

## Requirements
- R1: After power-on reset the words read as: control 1 = 0x0001, control 2 = 0x0004, control 3 = 0x0700, status 1 = 0x6040, status 2 = 0x4028, test = 0x0060, baud count = 0x0004, FIFO control = 0, baud modulator = 0, one-millisecond = 0, receive data = 0x4000. rx_ready is 1, and irq and tx_valid are 0.
- R2: Word index map: 0x00 receive data, 0x10 transmit data, 0x20 control 1, 0x21 control 2, 0x22 control 3, 0x23 control 4, 0x24 FIFO control, 0x25 status 1, 0x26 status 2, 0x29 baud increment, 0x2A baud modulator, 0x2B baud count, 0x2C one-millisecond, 0x2D test. A read drives bus_rdata in the cycle after the strobe, zero-extended from 16 bits, and bus_rdata then holds its value until the next read.
- R3: A read of word 0x00 returns the stored buffer value. If test bit 5 (empty) is 0, bit 15 of the returned word is set, and the same read clears status-1 bit 9 and status-2 bit 0 and sets test bit 5.
- R4: A character is taken when rx_valid and rx_ready are both high, and rx_ready equals NOT status-1 bit 9. Taking it stores {8'h00, rx_data}, or 0x0800 when rx_break is high. It also sets status-1 bit 9 and status-2 bit 0 and clears test bit 5.
- R5: A write to word 0x25 clears the status-1 bits that are 1 in the written value, but only bits 15, 12, 11, 10, 8, 7, 5 and 4. A write to word 0x26 clears status-2 bits the same way, but only bits 15, 13, 12, 11, 10, 8, 7, 6, 4, 2 and 1. Other written bits have no effect.
- R6: A write to word 0x21 with bit 0 equal to 0 restores the reset values of status 1, status 2, test, control 1 (to 0), control 3, baud modulator, baud count and the receive buffer (to 0x4000), which empties the slot. FIFO control and one-millisecond keep their contents. For every write to word 0x21, control 2 stores the written low 16 bits with bit 0 forced to 1.
- R7: irq is 1 when status-1 bit 9 and control-1 bit 9 are both 1, or when status-1 bit 13 and control-1 bits 13 and 6 are all 1. Otherwise irq is 0.
- R8: A write to word 0x10 while control-2 bit 2 is 1 produces tx_valid for exactly one cycle, in the cycle after the write, with tx_data equal to the low 8 bits written. While control-2 bit 2 is 0 the write has no effect.
- R9: Writes to words 0x20, 0x22, 0x24, 0x2A and 0x2C store the low 16 bits, and the same word reads them back. A write to word 0x29 sets the value read at word 0x2B. Words 0x23 and 0x29 read as 0.
- R10: Undecoded word indices read as 0 and ignore writes. Writes to words 0x2D and 0x23 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_addr | input | IDX_W | Word index (byte offset shifted right by two) |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, registered one cycle after bus_rd |
| rx_valid | input | 1 | Incoming character or break offered |
| rx_data | input | 8 | Incoming character |
| rx_break | input | 1 | Marks the offered item as a break |
| rx_ready | output | 1 | Receive slot free |
| tx_valid | output | 1 | One-cycle transmit byte strobe |
| tx_data | output | 8 | Transmit byte |
| irq | output | 1 | Level interrupt |

## Verification
The bench builds the block with its default widths: a 10-bit word index, which covers the whole 4 KiB window, and a 32-bit data bus. With these widths, indices far above the decoded range are reachable, and so are the upper data bits that the 16-bit registers must drop. A pseudo-random phase mixes reads, writes, received bytes and breaks on top of the directed cases. This reaches soft resets while a character is waiting, offers to a full slot, and write-one-to-clear values aimed at bits that are outside the masks.

// File: rtl/uart_rf_pkg.sv
package uart_rf_pkg;

    localparam int REG_W  = 16;
    localparam int BYTE_W = 8;

    // bit positions that several registers share
    localparam int ST1_RX_RDY  = 9;
    localparam int ST1_TX_RDY  = 13;
    localparam int ST2_DAT_RDY = 0;
    localparam int TST_RX_EMP  = 5;
    localparam int C1_RX_IE    = 9;
    localparam int C1_TX_IE    = 13;
    localparam int C1_TXE_IE   = 6;
    localparam int C2_NRST     = 0;
    localparam int C2_TX_EN    = 2;
    localparam int RXD_VALID   = 15;

    localparam logic [REG_W-1:0] ST1_RST   = 16'h6040;
    localparam logic [REG_W-1:0] ST2_RST   = 16'h4028;
    localparam logic [REG_W-1:0] TST_RST   = 16'h0060;
    localparam logic [REG_W-1:0] C3_RST    = 16'h0700;
    localparam logic [REG_W-1:0] BCNT_RST  = 16'h0004;
    localparam logic [REG_W-1:0] RXB_RST   = 16'h4000;
    localparam logic [REG_W-1:0] RXB_BREAK = 16'h0800;
    localparam logic [REG_W-1:0] ST1_CLRM  = 16'h9DB0;
    localparam logic [REG_W-1:0] ST2_CLRM  = 16'hBDD6;
    localparam logic [REG_W-1:0] C1_POR    = 16'h0001;
    localparam logic [REG_W-1:0] C2_POR    = 16'h0004;

    typedef enum logic [3:0] {
        SEL_NONE, SEL_RXD, SEL_TXD, SEL_CTL1, SEL_CTL2, SEL_CTL3, SEL_CTL4,
        SEL_FIFO, SEL_STAT1, SEL_STAT2, SEL_BINC, SEL_BMOD, SEL_BCNT,
        SEL_MSEC, SEL_TEST
    } reg_sel_e;

    typedef struct packed {
        logic [REG_W-1:0]  stat1;
        logic [REG_W-1:0]  stat2;
        logic [REG_W-1:0]  test;
        logic [REG_W-1:0]  ctl1;
        logic [REG_W-1:0]  ctl2;
        logic [REG_W-1:0]  ctl3;
        logic [REG_W-1:0]  fifo;
        logic [REG_W-1:0]  bmod;
        logic [REG_W-1:0]  bcnt;
        logic [REG_W-1:0]  msec;
        logic [REG_W-1:0]  rxbuf;
        logic              tx_vld;
        logic [BYTE_W-1:0] tx_byte;
    } rf_state_t;

endpackage

// File: rtl/uart_rf_decode.sv
module uart_rf_decode
    import uart_rf_pkg::*;
#(
    parameter int IDX_W = 10
) (
    input  logic [IDX_W-1:0] idx,
    output reg_sel_e         sel
);
    always_comb begin
        unique case (idx)
            IDX_W'(8'h00): sel = SEL_RXD;
            IDX_W'(8'h10): sel = SEL_TXD;
            IDX_W'(8'h20): sel = SEL_CTL1;
            IDX_W'(8'h21): sel = SEL_CTL2;
            IDX_W'(8'h22): sel = SEL_CTL3;
            IDX_W'(8'h23): sel = SEL_CTL4;
            IDX_W'(8'h24): sel = SEL_FIFO;
            IDX_W'(8'h25): sel = SEL_STAT1;
            IDX_W'(8'h26): sel = SEL_STAT2;
            IDX_W'(8'h29): sel = SEL_BINC;
            IDX_W'(8'h2A): sel = SEL_BMOD;
            IDX_W'(8'h2B): sel = SEL_BCNT;
            IDX_W'(8'h2C): sel = SEL_MSEC;
            IDX_W'(8'h2D): sel = SEL_TEST;
            default:       sel = SEL_NONE;
        endcase
    end
endmodule

// File: rtl/uart_rf_rdmux.sv
module uart_rf_rdmux
    import uart_rf_pkg::*;
(
    input  reg_sel_e         sel,
    input  rf_state_t        st,
    output logic [REG_W-1:0] word
);
    always_comb begin
        unique case (sel)
            SEL_RXD:   word = st.rxbuf;
            SEL_CTL1:  word = st.ctl1;
            SEL_CTL2:  word = st.ctl2;
            SEL_CTL3:  word = st.ctl3;
            SEL_FIFO:  word = st.fifo;
            SEL_STAT1: word = st.stat1;
            SEL_STAT2: word = st.stat2;
            SEL_BMOD:  word = st.bmod;
            SEL_BCNT:  word = st.bcnt;
            SEL_MSEC:  word = st.msec;
            SEL_TEST:  word = st.test;
            default:   word = '0;
        endcase
    end
endmodule

// File: rtl/uart_rf_irq.sv
module uart_rf_irq
    import uart_rf_pkg::*;
(
    input  logic [REG_W-1:0] stat1,
    input  logic [REG_W-1:0] ctl1,
    output logic             irq
);
    logic rx_term;
    logic tx_term;

    always_comb begin
        rx_term = stat1[ST1_RX_RDY] & ctl1[C1_RX_IE];
        tx_term = stat1[ST1_TX_RDY] & ctl1[C1_TX_IE] & ctl1[C1_TXE_IE];
        irq     = rx_term | tx_term;
    end
endmodule

// File: rtl/uart_regfront.sv
module uart_regfront
    import uart_rf_pkg::*;
#(
    parameter int IDX_W  = 10,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [IDX_W-1:0]  bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              rx_valid,
    input  logic [7:0]        rx_data,
    input  logic              rx_break,
    output logic              rx_ready,
    output logic              tx_valid,
    output logic [7:0]        tx_data,
    output logic              irq
);
    localparam int PAD_W = DATA_W - REG_W;

    rf_state_t         st_d, st_q;
    logic [DATA_W-1:0] rdata_d, rdata_q;
    reg_sel_e          sel;
    logic [REG_W-1:0]  rd_word;
    logic [REG_W-1:0]  wr_word;
    logic [REG_W-1:0]  ctl1_v;
    logic [REG_W-1:0]  ctl2_v;

    assign ctl1_v  = st_q.ctl1;
    assign ctl2_v  = st_q.ctl2;
    assign wr_word = bus_wdata[REG_W-1:0];

    uart_rf_decode #(.IDX_W(IDX_W)) u_dec (
        .idx (bus_addr),
        .sel (sel)
    );

    uart_rf_rdmux u_rdmux (
        .sel  (sel),
        .st   (st_q),
        .word (rd_word)
    );

    uart_rf_irq u_irq (
        .stat1 (st_q.stat1),
        .ctl1  (ctl1_v),
        .irq   (irq)
    );

    always_comb begin
        st_d        = st_q;
        rdata_d     = rdata_q;
        st_d.tx_vld = 1'b0;

        // read side effects use the current state
        if (bus_rd) begin
            rdata_d = {{PAD_W{1'b0}}, rd_word};
            if (sel == SEL_RXD && !st_q.test[TST_RX_EMP]) begin
                rdata_d[RXD_VALID]       = 1'b1;
                st_d.stat1[ST1_RX_RDY]   = 1'b0;
                st_d.stat2[ST2_DAT_RDY]  = 1'b0;
                st_d.test[TST_RX_EMP]    = 1'b1;
            end
        end

        // receive handshake
        if (rx_valid && rx_ready) begin
            st_d.stat1[ST1_RX_RDY]  = 1'b1;
            st_d.stat2[ST2_DAT_RDY] = 1'b1;
            st_d.test[TST_RX_EMP]   = 1'b0;
            st_d.rxbuf = rx_break ? RXB_BREAK : {{(REG_W-8){1'b0}}, rx_data};
        end

        // bus writes, soft reset last so it wins
        if (bus_wr) begin
            unique case (sel)
                SEL_TXD: begin
                    if (ctl2_v[C2_TX_EN]) begin
                        st_d.tx_vld  = 1'b1;
                        st_d.tx_byte = bus_wdata[7:0];
                    end
                end
                SEL_CTL1:  st_d.ctl1  = wr_word;
                SEL_CTL3:  st_d.ctl3  = wr_word;
                SEL_FIFO:  st_d.fifo  = wr_word;
                SEL_BMOD:  st_d.bmod  = wr_word;
                SEL_MSEC:  st_d.msec  = wr_word;
                SEL_BINC:  st_d.bcnt  = wr_word;
                SEL_STAT1: st_d.stat1 = st_d.stat1 & ~(wr_word & ST1_CLRM);
                SEL_STAT2: st_d.stat2 = st_d.stat2 & ~(wr_word & ST2_CLRM);
                SEL_CTL2: begin
                    if (!wr_word[C2_NRST]) begin
                        st_d.stat1 = ST1_RST;
                        st_d.stat2 = ST2_RST;
                        st_d.test  = TST_RST;
                        st_d.ctl1  = '0;
                        st_d.ctl3  = C3_RST;
                        st_d.bmod  = '0;
                        st_d.bcnt  = BCNT_RST;
                        st_d.rxbuf = RXB_RST;
                    end
                    st_d.ctl2 = wr_word | REG_W'(1);
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.stat1   <= ST1_RST;
            st_q.stat2   <= ST2_RST;
            st_q.test    <= TST_RST;
            st_q.ctl1    <= C1_POR;
            st_q.ctl2    <= C2_POR;
            st_q.ctl3    <= C3_RST;
            st_q.fifo    <= '0;
            st_q.bmod    <= '0;
            st_q.bcnt    <= BCNT_RST;
            st_q.msec    <= '0;
            st_q.rxbuf   <= RXB_RST;
            st_q.tx_vld  <= 1'b0;
            st_q.tx_byte <= '0;
            rdata_q      <= '0;
        end else begin
            st_q    <= st_d;
            rdata_q <= rdata_d;
        end
    end

    assign rx_ready  = !st_q.stat1[ST1_RX_RDY];
    assign tx_valid  = st_q.tx_vld;
    assign tx_data   = st_q.tx_byte;
    assign bus_rdata = rdata_q;

endmodule

// File: rtl/uart_regfront_chk.sv
module uart_regfront_chk
    import uart_rf_pkg::*;
#(
    parameter int IDX_W  = 10,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic [IDX_W-1:0]  bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic              rx_valid,
    input logic              rx_ready,
    input logic              tx_valid,
    input logic [7:0]        tx_data,
    input logic              irq,
    input logic [REG_W-1:0]  ctl1_v,
    input logic [REG_W-1:0]  ctl2_v
);
    localparam logic [IDX_W-1:0] I_RXD  = IDX_W'(8'h00);
    localparam logic [IDX_W-1:0] I_TXD  = IDX_W'(8'h10);
    localparam logic [IDX_W-1:0] I_CTL2 = IDX_W'(8'h21);

    logic live_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) live_q <= 1'b0;
        else        live_q <= 1'b1;
    end

    logic srst_wr;
    assign srst_wr = bus_wr && bus_addr == I_CTL2 && !bus_wdata[0];

    // R4: a taken character fills the slot
    a_r4_take_fills: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && rx_ready && !srst_wr) |=> !rx_ready);

    // R4: a full slot stays full until a data read or a soft reset
    a_r4_full_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!rx_ready && !(bus_rd && bus_addr == I_RXD) && !srst_wr) |=> !rx_ready);

    // R3: reading the data word frees the slot
    a_r3_read_frees: assert property (@(posedge clk) disable iff (!rst_n)
        (!rx_ready && bus_rd && bus_addr == I_RXD) |=> rx_ready);

    // R6: control 2 always holds bit 0 after a write to it
    a_r6_nrst_forced: assert property (@(posedge clk) disable iff (!rst_n || !live_q)
        $past(bus_wr && bus_addr == I_CTL2) |-> ctl2_v[0]);

    // R8: every transmit strobe comes from an enabled data write one cycle earlier
    a_r8_tx_source: assert property (@(posedge clk) disable iff (!rst_n || !live_q)
        tx_valid |-> ($past(bus_wr) && $past(bus_addr) == I_TXD
                      && tx_data == $past(bus_wdata[7:0]) && $past(ctl2_v[2])));

    // R7: a waiting character with its enable raises the interrupt
    a_r7_rx_irq: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl1_v[9] && !rx_ready) |-> irq);

    // R7: no enables, no interrupt
    a_r7_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctl1_v[9] && !ctl1_v[6]) |-> !irq);

endmodule

bind uart_regfront uart_regfront_chk #(.IDX_W(IDX_W), .DATA_W(DATA_W)) u_chk (.*);

// File: tb/uart_regfront_bench.sv
`timescale 1ns/1ps
module uart_regfront_bench;
    localparam int IDX_W  = 10;
    localparam int DATA_W = 32;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              bus_wr = 1'b0, bus_rd = 1'b0;
    logic [IDX_W-1:0]  bus_addr = '0;
    logic [DATA_W-1:0] bus_wdata = '0;
    logic [DATA_W-1:0] bus_rdata;
    logic              rx_valid = 1'b0, rx_break = 1'b0;
    logic [7:0]        rx_data = '0;
    logic              rx_ready, tx_valid, irq;
    logic [7:0]        tx_data;

    always #2.5 clk = ~clk;

    uart_regfront #(.IDX_W(IDX_W), .DATA_W(DATA_W)) u_uart_regfront (.*);

    int n_cmp = 0, n_bad = 0;
    bit done = 1'b0;

    // behavioural reference state
    int m_s1, m_s2, m_tst, m_c1, m_c2, m_c3, m_fifo, m_bmod, m_bcnt, m_msec, m_rxb;
    int m_rdata, m_txd;
    bit m_txv;

    function automatic void m_por();
        m_s1 = 'h6040; m_s2 = 'h4028; m_tst = 'h60; m_c1 = 1; m_c2 = 4;
        m_c3 = 'h700; m_fifo = 0; m_bmod = 0; m_bcnt = 4; m_msec = 0;
        m_rxb = 'h4000; m_rdata = 0; m_txv = 0; m_txd = 0;
    endfunction

    function automatic int m_word(int idx);
        case (idx)
            'h00: return m_rxb;   'h20: return m_c1;   'h21: return m_c2;
            'h22: return m_c3;    'h24: return m_fifo; 'h25: return m_s1;
            'h26: return m_s2;    'h2A: return m_bmod; 'h2B: return m_bcnt;
            'h2C: return m_msec;  'h2D: return m_tst;
            default: return 0;
        endcase
    endfunction

    function automatic bit m_irq();
        int a = m_s1 & m_c1;
        return ((a & 'h200) != 0) || (((a & 'h2000) != 0) && ((m_c1 & 'h40) != 0));
    endfunction

    function automatic void m_step(bit wr, bit rd, int idx, int wd, bit rv, int rdat, bit rb);
        int s1 = m_s1, s2 = m_s2, t = m_tst, rxb = m_rxb;
        int c1 = m_c1, c2 = m_c2, c3 = m_c3, bm = m_bmod, bc = m_bcnt;
        int w = wd & 'hFFFF;
        m_txv = 0;
        if (rd) begin
            m_rdata = m_word(idx);
            if (idx == 0 && (m_tst & 'h20) == 0) begin
                m_rdata |= 'h8000; s1 &= ~'h200; s2 &= ~1; t |= 'h20;
            end
        end
        if (rv && (m_s1 & 'h200) == 0) begin
            s1 |= 'h200; s2 |= 1; t &= ~'h20;
            rxb = rb ? 'h800 : (rdat & 'hFF);
        end
        if (wr) begin
            case (idx)
                'h10: if ((m_c2 & 4) != 0) begin m_txv = 1; m_txd = wd & 'hFF; end
                'h20: c1 = w;
                'h22: c3 = w;
                'h24: m_fifo = w;
                'h2A: bm = w;
                'h2C: m_msec = w;
                'h29: bc = w;
                'h25: s1 &= ~(w & 'h9DB0);
                'h26: s2 &= ~(w & 'hBDD6);
                'h21: begin
                    if ((w & 1) == 0) begin
                        s1 = 'h6040; s2 = 'h4028; t = 'h60; c1 = 0; c3 = 'h700;
                        bm = 0; bc = 4; rxb = 'h4000;
                    end
                    c2 = w | 1;
                end
                default: ;
            endcase
        end
        m_s1 = s1; m_s2 = s2; m_tst = t; m_rxb = rxb; m_c1 = c1; m_c2 = c2;
        m_c3 = c3; m_bmod = bm; m_bcnt = bc;
    endfunction

    task automatic cmp(string tag, string what, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
        end
    endtask

    task automatic compare_all(string tag);
        cmp(tag, "bus_rdata", int'(bus_rdata), m_rdata);
        cmp(tag, "rx_ready", int'(rx_ready), int'((m_s1 & 'h200) == 0));
        cmp(tag, "irq", int'(irq), int'(m_irq()));
        cmp(tag, "tx_valid", int'(tx_valid), int'(m_txv));
        if (m_txv) cmp(tag, "tx_data", int'(tx_data), m_txd);
    endtask

    task automatic step(string tag, bit wr, bit rd, int idx, int wd,
                        bit rv = 0, int rdat = 0, bit rb = 0);
        @(negedge clk);
        bus_wr = wr; bus_rd = rd; bus_addr = IDX_W'(idx); bus_wdata = DATA_W'(wd);
        rx_valid = rv; rx_data = 8'(rdat); rx_break = rb;
        m_step(wr, rd, idx, wd, rv, rdat, rb);
        @(posedge clk);
        #1;
        bus_wr = 0; bus_rd = 0; rx_valid = 0; rx_break = 0;
        compare_all(tag);
    endtask

    task automatic rd_chk(string tag, int idx, int exp);
        step(tag, 0, 1, idx, 0);
        cmp(tag, "read value", int'(bus_rdata), exp);
    endtask

    task automatic wr(string tag, int idx, int wd);
        step(tag, 1, 0, idx, wd);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin : stim
        int lfsr = 'h1ACE;
        m_por();
        repeat (3) @(posedge clk);
        #1;
        compare_all("R1");
        rst_n = 1'b1;
        // R1 power-on values
        rd_chk("R1", 'h20, 'h0001); rd_chk("R1", 'h21, 'h0004);
        rd_chk("R1", 'h22, 'h0700); rd_chk("R1", 'h25, 'h6040);
        rd_chk("R1", 'h26, 'h4028); rd_chk("R1", 'h2D, 'h0060);
        rd_chk("R1", 'h2B, 'h0004); rd_chk("R1", 'h00, 'h4000);
        // R8 transmit gated by control-2 bit 2
        wr("R8", 'h10, 'h1A5);
        cmp("R8", "tx byte", int'(tx_data), 'hA5);
        wr("R8", 'h21, 'h0001);
        wr("R8", 'h10, 'h77);
        cmp("R8", "tx ignored", int'(tx_valid), 0);
        // R4 receive, R3 data read
        step("R4", 0, 0, 0, 0, 1, 'h3C, 0);
        cmp("R4", "slot full", int'(rx_ready), 0);
        rd_chk("R4", 'h25, 'h6240); rd_chk("R4", 'h26, 'h4029); rd_chk("R4", 'h2D, 'h0040);
        step("R4", 0, 0, 0, 0, 1, 'h99, 0);
        rd_chk("R3", 'h00, 'h803C);
        rd_chk("R3", 'h00, 'h003C);
        step("R4", 0, 0, 0, 0, 1, 'h00, 1);
        rd_chk("R4", 'h00, 'h8800);
        // R7 interrupt
        wr("R7", 'h20, 'h0200);
        step("R7", 0, 0, 0, 0, 1, 'h55, 0);
        cmp("R7", "irq rx", int'(irq), 1);
        rd_chk("R7", 'h00, 'h8055);
        cmp("R7", "irq released", int'(irq), 0);
        wr("R7", 'h20, 'h2000);
        cmp("R7", "tx term needs enable", int'(irq), 0);
        wr("R7", 'h20, 'h2040);
        cmp("R7", "irq tx", int'(irq), 1);
        // R5 write-one-to-clear masks
        step("R5", 0, 0, 0, 0, 1, 'h12, 0);
        wr("R5", 'h25, 'hFFFF); rd_chk("R5", 'h25, 'h6240);
        wr("R5", 'h26, 'hFFFF); rd_chk("R5", 'h26, 'h4029);
        // R9 stored words
        wr("R9", 'h22, 'hABCD1234); rd_chk("R9", 'h22, 'h1234);
        wr("R9", 'h24, 'h0F0F); rd_chk("R9", 'h24, 'h0F0F);
        wr("R9", 'h2A, 'h5A5A); rd_chk("R9", 'h2A, 'h5A5A);
        wr("R9", 'h2C, 'h00C8); rd_chk("R9", 'h2C, 'h00C8);
        wr("R9", 'h29, 'h0321); rd_chk("R9", 'h2B, 'h0321);
        rd_chk("R9", 'h29, 0); rd_chk("R9", 'h23, 0);
        // R10 ignored writes and undecoded reads
        wr("R10", 'h2D, 'hFFFF); rd_chk("R10", 'h2D, 'h0040);
        wr("R10", 'h23, 'hFFFF); rd_chk("R10", 'h23, 0);
        wr("R10", 'h3FF, 'hFFFF); rd_chk("R10", 'h3FF, 0);
        rd_chk("R10", 'h10, 0);
        // R6 soft reset with a character waiting
        wr("R6", 'h21, 'h0006);
        rd_chk("R6", 'h21, 'h0007); rd_chk("R6", 'h20, 0);
        rd_chk("R6", 'h22, 'h0700); rd_chk("R6", 'h2B, 'h0004);
        rd_chk("R6", 'h2A, 0);      rd_chk("R6", 'h24, 'h0F0F);
        rd_chk("R6", 'h2C, 'h00C8); rd_chk("R6", 'h00, 'h4000);
        cmp("R6", "slot free", int'(rx_ready), 1);
        // R2 mixed traffic against the model
        for (int i = 0; i < 3000; i++) begin
            int idx, wd;
            bit dw, dr;
            lfsr = (lfsr >> 1) ^ ((lfsr & 1) != 0 ? 'hB400 : 0);
            case (lfsr % 8)
                0: idx = 'h00; 1: idx = 'h10; 2: idx = 'h20; 3: idx = 'h21;
                4: idx = 'h25; 5: idx = 'h26; 6: idx = 'h29 + (lfsr % 5);
                default: idx = (lfsr >> 3) & 'h3FF;
            endcase
            dw = ((lfsr >> 4) & 3) == 0;
            dr = !dw && ((lfsr >> 6) & 1);
            wd = (lfsr * 'h9E37) ^ (lfsr << 16);
            if (idx == 'h21 && ((lfsr >> 9) & 7) != 0) wd |= 1;
            step("R2", dw, dr, idx, wd, ((lfsr >> 7) & 1), lfsr >> 2, ((lfsr >> 11) & 7) == 0);
        end
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule